// File: doc/BRIEF.md
# Streaming Tile Transpose Engine

This block sits inside a memory-copy datapath and transposes a matrix on the fly. The source matrix has M rows and N columns of elements, each 1, 2 or 4 bytes wide, and arrives as a valid/ready stream of fixed-width beats. One beat carries NE elements, where NE is the beat width in bytes divided by the element size. The block cuts the matrix into square NE-by-NE tiles. It collects each tile in a buffer bank and then sends the tile out column by column, so every output beat is one row of the transposed matrix.

Matrix edges are handled with a per-byte write strobe and never with padded data. Lanes that fall below the last source row are masked. Columns that lie past the last source column are still emitted, as beats whose strobe is all zero. The downstream address sequence therefore stays regular.

A parameter selects between two banks and one bank. With two banks one tile fills while the previous tile drains. With one bank, fill and drain take turns. A synchronous clear abandons the current transfer and prepares the block for the next one.

Top module: `tile_xpose`

## Requirements
- R1: The element size code `esz` selects 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, with NE = BEAT_BYTES / size. Element e of a beat occupies bytes e*size to e*size+size-1. Byte lane r*size+b of output beat c of a tile holds byte b of the element at tile row r, tile column c.
- R2: Tiles are visited with the tile column index running fastest (row-major over the source). A tile takes min(NE, M - tile_row*NE) input beats, one per source row, and always gives NE output beats, in column order.
- R3: Output lanes whose tile row lies at or beyond M carry strobe 0. The strobe of every valid beat is a contiguous run of ones starting at lane 0.
- R4: An output beat whose column lies at or beyond N is still emitted, and it carries an all-zero strobe.
- R5: With two banks and no output stall, the 16 rows of two stacked tiles are accepted in 16 consecutive cycles.
- R6: With one bank, no input beat is accepted while a tile is draining. For two stacked 8-row tiles, the first and last row acceptances are 23 cycles apart.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_strb` hold their values.
- R8: After reset or a one-cycle `clear`, `out_valid` is low and `in_ready` is high in the following cycle. Any partial tile is dropped.
- R9: Once the last row of the last tile is accepted, `in_ready` stays low until `clear`.
- R10: The first column of a tile is valid at the output in the cycle after its last row is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clear | input | 1 | Synchronous abort; returns the block to idle |
| esz | input | 2 | Element size code (0: 1 B, 1: 2 B, 2: 4 B) |
| dim_m | input | DIM_W | Source row count M, held for the transfer |
| dim_n | input | DIM_W | Source column count N, held for the transfer |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Input beat accepted this cycle if valid |
| in_data | input | 8*BEAT_BYTES | One source row segment of a tile |
| out_valid | output | 1 | Output beat valid |
| out_ready | input | 1 | Output beat consumed this cycle if valid |
| out_data | output | 8*BEAT_BYTES | One column of the current tile |
| out_strb | output | BEAT_BYTES | Per-byte write strobe |

## Verification
In the two-bank build, filling one bank and draining the other happen in the same cycle. On the cycle a tile completes, the fill side also moves to the next bank while the drain side may be releasing its own. The bench provokes this with back-to-back tall shapes under no stall, which must give full throughput, and with random stalls on both streams. It judges the result by comparing every strobed byte against a software transpose and by checking the spacing between input acceptances. In the one-bank build the same stimulus must never show an input acceptance while the output is valid.

// File: rtl/tile_xpose_pkg.sv
package tile_xpose_pkg;

    // Element size codes carried on the esz port
    typedef enum logic [1:0] {
        ESZ_B1 = 2'd0,
        ESZ_B2 = 2'd1,
        ESZ_B4 = 2'd2
    } esz_e;

    // Width of the per-tile row/column counts kept with each bank
    localparam int META_W = 8;

    typedef struct packed {
        logic [META_W-1:0] rows;   // valid source rows in the tile
        logic [META_W-1:0] cols;   // valid source columns in the tile
    } tile_meta_t;

    // log2 of the element size in bytes; an unused code falls back to 1 byte
    function automatic logic [1:0] esz_shift(logic [1:0] code);
        case (code)
            ESZ_B2:  return 2'd1;
            ESZ_B4:  return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

endpackage

// File: rtl/xpose_bank.sv
module xpose_bank #(
    parameter int BEAT_BYTES = 8
) (
    input  logic                             clk,
    input  logic                             wr_en,
    input  logic [$clog2(BEAT_BYTES)-1:0]    wr_row,
    input  logic [BEAT_BYTES-1:0][7:0]       wr_data,
    input  logic [$clog2(BEAT_BYTES)-1:0]    rd_col,
    input  logic [1:0]                       shift,
    output logic [BEAT_BYTES-1:0][7:0]       rd_data
);
    localparam int COL_W = $clog2(BEAT_BYTES);

    // One tile: BEAT_BYTES rows, each a full beat of bytes
    logic [BEAT_BYTES-1:0][BEAT_BYTES-1:0][7:0] mem_q;

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_row] <= wr_data;
        end
    end

    // Output byte k = byte (k mod size) of the element in row k/size, column rd_col
    for (genvar k = 0; k < BEAT_BYTES; k++) begin : g_lane
        logic [COL_W-1:0] r_idx;
        logic [COL_W-1:0] c_idx;
        always_comb begin
            r_idx      = COL_W'(k >> shift);
            c_idx      = COL_W'((int'(rd_col) << shift) + (k & ((1 << shift) - 1)));
            rd_data[k] = mem_q[r_idx][c_idx];
        end
    end

endmodule

// File: rtl/xpose_fill.sv
module xpose_fill
    import tile_xpose_pkg::*;
#(
    parameter int BEAT_BYTES = 8,
    parameter int DIM_W      = 8,
    parameter int NBANK      = 2,
    localparam int COL_W     = $clog2(BEAT_BYTES),
    localparam int NE_W      = $clog2(BEAT_BYTES + 1),
    localparam int BANK_W    = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic [NE_W-1:0]   ne,
    input  logic [DIM_W-1:0]  dim_m,
    input  logic [DIM_W-1:0]  dim_n,
    input  logic              in_valid,
    input  logic [NBANK-1:0]  bank_full,
    output logic              in_ready,
    output logic              wr_en,
    output logic [COL_W-1:0]  wr_row,
    output logic [BANK_W-1:0] wr_bank,
    output logic              commit,
    output tile_meta_t        commit_meta
);
    logic [DIM_W:0]    base_r_q, base_c_q;
    logic [COL_W-1:0]  row_q;
    logic [BANK_W-1:0] bank_q;
    logic              done_q;

    logic [DIM_W:0]    rem_r, rem_c, ne_ext;
    logic [NE_W-1:0]   rows_v, cols_v;
    logic              fire, last_row, last_tc, last_tr;
    logic [BANK_W-1:0] bank_nx;

    always_comb begin
        ne_ext   = (DIM_W+1)'(ne);
        rem_r    = {1'b0, dim_m} - base_r_q;
        rem_c    = {1'b0, dim_n} - base_c_q;
        rows_v   = (rem_r >= ne_ext) ? ne : NE_W'(rem_r);
        cols_v   = (rem_c >= ne_ext) ? ne : NE_W'(rem_c);
        in_ready = !done_q && !bank_full[bank_q];
        fire     = in_valid && in_ready;
        last_row = (NE_W'(row_q) + NE_W'(1)) == rows_v;
        last_tc  = (base_c_q + ne_ext) >= {1'b0, dim_n};
        last_tr  = (base_r_q + ne_ext) >= {1'b0, dim_m};
        bank_nx  = (bank_q == BANK_W'(NBANK - 1)) ? '0 : bank_q + BANK_W'(1);
    end

    assign wr_en            = fire;
    assign wr_row           = row_q;
    assign wr_bank          = bank_q;
    assign commit           = fire && last_row;
    assign commit_meta.rows = META_W'(rows_v);
    assign commit_meta.cols = META_W'(cols_v);

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            base_r_q <= '0;
            base_c_q <= '0;
            row_q    <= '0;
            bank_q   <= '0;
            done_q   <= 1'b0;
        end else if (fire) begin
            if (last_row) begin
                row_q  <= '0;
                bank_q <= bank_nx;
                if (last_tc) begin
                    base_c_q <= '0;
                    if (last_tr) begin
                        done_q <= 1'b1;
                    end else begin
                        base_r_q <= base_r_q + ne_ext;
                    end
                end else begin
                    base_c_q <= base_c_q + ne_ext;
                end
            end else begin
                row_q <= row_q + COL_W'(1);
            end
        end
    end

endmodule

// File: rtl/xpose_drain.sv
module xpose_drain #(
    parameter int BEAT_BYTES = 8,
    parameter int NBANK      = 2,
    localparam int COL_W     = $clog2(BEAT_BYTES),
    localparam int NE_W      = $clog2(BEAT_BYTES + 1),
    localparam int BANK_W    = (NBANK > 1) ? $clog2(NBANK) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic [NE_W-1:0]   ne,
    input  logic [NBANK-1:0]  bank_full,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [COL_W-1:0]  rd_col,
    output logic [BANK_W-1:0] rd_bank,
    output logic              release_bank
);
    logic [COL_W-1:0]  col_q;
    logic [BANK_W-1:0] bank_q;
    logic              fire, last_col;

    always_comb begin
        out_valid    = bank_full[bank_q];
        fire         = out_valid && out_ready;
        last_col     = (NE_W'(col_q) + NE_W'(1)) == ne;
        release_bank = fire && last_col;
    end

    assign rd_col  = col_q;
    assign rd_bank = bank_q;

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            col_q  <= '0;
            bank_q <= '0;
        end else if (fire) begin
            if (last_col) begin
                col_q  <= '0;
                bank_q <= (bank_q == BANK_W'(NBANK - 1)) ? '0 : bank_q + BANK_W'(1);
            end else begin
                col_q <= col_q + COL_W'(1);
            end
        end
    end

endmodule

// File: rtl/tile_xpose.sv
module tile_xpose
    import tile_xpose_pkg::*;
#(
    parameter int BEAT_BYTES  = 8,
    parameter int DIM_W       = 8,
    parameter bit FULL_DUPLEX = 1'b1
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    clear,
    input  logic [1:0]              esz,
    input  logic [DIM_W-1:0]        dim_m,
    input  logic [DIM_W-1:0]        dim_n,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [8*BEAT_BYTES-1:0] in_data,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [8*BEAT_BYTES-1:0] out_data,
    output logic [BEAT_BYTES-1:0]   out_strb
);
    localparam int NBANK  = FULL_DUPLEX ? 2 : 1;
    localparam int COL_W  = $clog2(BEAT_BYTES);
    localparam int NE_W   = $clog2(BEAT_BYTES + 1);
    localparam int BANK_W = (NBANK > 1) ? $clog2(NBANK) : 1;

    logic [1:0]              shift;
    logic [NE_W-1:0]         ne;
    logic [BEAT_BYTES-1:0][7:0] in_bytes;

    assign shift    = esz_shift(esz);
    assign ne       = NE_W'(BEAT_BYTES >> shift);
    assign in_bytes = in_data;

    logic [NBANK-1:0]  full_q;
    tile_meta_t        meta_q [NBANK];

    logic              wr_en, commit, release_bank;
    logic [COL_W-1:0]  wr_row, rd_col;
    logic [BANK_W-1:0] wr_bank, rd_bank;
    tile_meta_t        commit_meta;

    xpose_fill #(
        .BEAT_BYTES (BEAT_BYTES),
        .DIM_W      (DIM_W),
        .NBANK      (NBANK)
    ) u_fill (
        .clk         (clk),
        .rst         (rst),
        .clear       (clear),
        .ne          (ne),
        .dim_m       (dim_m),
        .dim_n       (dim_n),
        .in_valid    (in_valid),
        .bank_full   (full_q),
        .in_ready    (in_ready),
        .wr_en       (wr_en),
        .wr_row      (wr_row),
        .wr_bank     (wr_bank),
        .commit      (commit),
        .commit_meta (commit_meta)
    );

    xpose_drain #(
        .BEAT_BYTES (BEAT_BYTES),
        .NBANK      (NBANK)
    ) u_drain (
        .clk          (clk),
        .rst          (rst),
        .clear        (clear),
        .ne           (ne),
        .bank_full    (full_q),
        .out_ready    (out_ready),
        .out_valid    (out_valid),
        .rd_col       (rd_col),
        .rd_bank      (rd_bank),
        .release_bank (release_bank)
    );

    logic [BEAT_BYTES-1:0][7:0] bank_rd [NBANK];

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        xpose_bank #(
            .BEAT_BYTES (BEAT_BYTES)
        ) u_bank (
            .clk     (clk),
            .wr_en   (wr_en && (wr_bank == BANK_W'(b))),
            .wr_row  (wr_row),
            .wr_data (in_bytes),
            .rd_col  (rd_col),
            .shift   (shift),
            .rd_data (bank_rd[b])
        );

        // Occupancy: set when the fill side completes a tile here, cleared
        // when the drain side sends the tile's last column.
        always_ff @(posedge clk) begin
            if (rst || clear) begin
                full_q[b] <= 1'b0;
                meta_q[b] <= '0;
            end else if (commit && (wr_bank == BANK_W'(b))) begin
                full_q[b] <= 1'b1;
                meta_q[b] <= commit_meta;
            end else if (release_bank && (rd_bank == BANK_W'(b))) begin
                full_q[b] <= 1'b0;
            end
        end
    end

    tile_meta_t sel_meta;
    assign sel_meta = meta_q[rd_bank];
    assign out_data = bank_rd[rd_bank];

    // Edge masking: lanes past the last source row, whole beats past the last column
    for (genvar k = 0; k < BEAT_BYTES; k++) begin : g_strb
        assign out_strb[k] = (META_W'(k >> shift) < sel_meta.rows) &&
                             (META_W'(rd_col) < sel_meta.cols);
    end

endmodule

// File: rtl/tile_xpose_chk.sv
module tile_xpose_chk #(
    parameter int BEAT_BYTES  = 8,
    parameter bit FULL_DUPLEX = 1'b1
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    clear,
    input logic                    in_valid,
    input logic                    in_ready,
    input logic                    out_valid,
    input logic                    out_ready,
    input logic [8*BEAT_BYTES-1:0] out_data,
    input logic [BEAT_BYTES-1:0]   out_strb
);
    logic [BEAT_BYTES-1:0] strb_inc;
    assign strb_inc = out_strb + 1'b1;

    // R8: reset leaves the output quiet
    assert_reset_quiet_R8: assert property (@(posedge clk)
        rst |=> !out_valid);

    // R8: clear returns to idle, ready for a new transfer
    assert_clear_idle_R8: assert property (@(posedge clk) disable iff (rst)
        clear |=> (!out_valid && in_ready));

    // R7: stalled output holds
    assert_stall_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_ready && !clear) |=>
            (out_valid && $stable(out_data) && $stable(out_strb)));

    // R3: strobe is a run of ones from lane 0 (or empty)
    assert_strb_prefix_R3: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> ((strb_inc & out_strb) == '0));

    // R6: one bank never fills while draining
    assert_half_no_overlap_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_ready) |-> (FULL_DUPLEX || !out_valid));

endmodule

bind tile_xpose tile_xpose_chk #(
    .BEAT_BYTES  (BEAT_BYTES),
    .FULL_DUPLEX (FULL_DUPLEX)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clear     (clear),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_strb  (out_strb)
);

// File: tb/sim_tile_xpose.sv
`timescale 1ns/1ps
module sim_tile_xpose;

    localparam int BB = 8;

    typedef struct packed {
        logic [1:0]  esz;
        logic [7:0]  m;
        logic [7:0]  n;
        logic        half;
        logic        bp;
        logic [15:0] beats;
    } vec_t;

    // shape, bank mode, stall mode, expected output beat count (R2)
    localparam vec_t VECS [0:11] = '{
        '{2'd0, 8'd8,  8'd8,  1'b0, 1'b1, 16'd8},
        '{2'd0, 8'd16, 8'd16, 1'b0, 1'b1, 16'd32},
        '{2'd0, 8'd6,  8'd8,  1'b0, 1'b1, 16'd8},
        '{2'd0, 8'd8,  8'd6,  1'b0, 1'b1, 16'd8},
        '{2'd0, 8'd5,  8'd7,  1'b0, 1'b1, 16'd8},
        '{2'd1, 8'd5,  8'd5,  1'b0, 1'b1, 16'd16},
        '{2'd2, 8'd3,  8'd5,  1'b0, 1'b1, 16'd12},
        '{2'd0, 8'd13, 8'd19, 1'b1, 1'b1, 16'd48},
        '{2'd1, 8'd7,  8'd5,  1'b1, 1'b1, 16'd16},
        '{2'd2, 8'd5,  8'd3,  1'b1, 1'b1, 16'd12},
        '{2'd0, 8'd1,  8'd1,  1'b0, 1'b0, 16'd8},
        '{2'd0, 8'd13, 8'd19, 1'b0, 1'b1, 16'd48}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic clear = 1'b0;
    logic [1:0] esz = 2'd0;
    logic [7:0] dim_m = 8'd8, dim_n = 8'd8;
    logic i_valid = 1'b0;
    logic [8*BB-1:0] i_data = '0;
    logic o_ready = 1'b1;
    logic sel = 1'b0;

    logic in_ready0, in_ready1, out_valid0, out_valid1;
    logic [8*BB-1:0] out_data0, out_data1;
    logic [BB-1:0] out_strb0, out_strb1;

    always #4 clk = ~clk;   // 125 MHz

    tile_xpose #(.BEAT_BYTES(BB), .DIM_W(8), .FULL_DUPLEX(1'b1)) u0 (
        .clk(clk), .rst(rst), .clear(clear), .esz(esz), .dim_m(dim_m), .dim_n(dim_n),
        .in_valid(i_valid && !sel), .in_ready(in_ready0), .in_data(i_data),
        .out_valid(out_valid0), .out_ready(o_ready && !sel),
        .out_data(out_data0), .out_strb(out_strb0));

    tile_xpose #(.BEAT_BYTES(BB), .DIM_W(8), .FULL_DUPLEX(1'b0)) u1 (
        .clk(clk), .rst(rst), .clear(clear), .esz(esz), .dim_m(dim_m), .dim_n(dim_n),
        .in_valid(i_valid && sel), .in_ready(in_ready1), .in_data(i_data),
        .out_valid(out_valid1), .out_ready(o_ready && sel),
        .out_data(out_data1), .out_strb(out_strb1));

    logic i_rdy, o_vld;
    logic [8*BB-1:0] o_dat;
    logic [BB-1:0] o_stb;
    assign i_rdy = sel ? in_ready1 : in_ready0;
    assign o_vld = sel ? out_valid1 : out_valid0;
    assign o_dat = sel ? out_data1 : out_data0;
    assign o_stb = sel ? out_strb1 : out_strb0;

    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    int first_fire, last_fire;
    bit finished = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] src_byte(int i, int j, int b, int seed);
        return 8'((i * 29 + j * 7 + b * 101 + seed * 13) & 255);
    endfunction

    task automatic pulse_clear();
        clear = 1'b1;
        @(posedge clk); #1;
        clear = 1'b0;
    endtask

    // Offer one beat, optionally after idle cycles; leaves valid high afterwards
    task automatic send_beat(input logic [8*BB-1:0] d, input bit bp);
        bit fire;
        if (bp && $urandom_range(0, 2) == 0) begin
            i_valid = 1'b0;
            repeat ($urandom_range(1, 3)) begin @(posedge clk); #1; end
        end
        i_data  = d;
        i_valid = 1'b1;
        do begin
            @(negedge clk);
            fire = i_valid && i_rdy;
            if (fire) begin
                if (first_fire < 0) first_fire = cyc;
                last_fire = cyc;
            end
            @(posedge clk); #1;
        end while (!fire);
    endtask

    task automatic producer(input int shf, input int m, input int n, input bit bp, input int seed);
        int ne, esb, tr_n, tc_n;
        ne = BB >> shf; esb = 1 << shf;
        tr_n = (m + ne - 1) / ne; tc_n = (n + ne - 1) / ne;
        for (int tr = 0; tr < tr_n; tr++) begin
            for (int tc = 0; tc < tc_n; tc++) begin
                for (int r = 0; r < ne && tr * ne + r < m; r++) begin
                    logic [8*BB-1:0] d;
                    for (int e = 0; e < ne; e++) begin
                        for (int b = 0; b < esb; b++) begin
                            int j;
                            j = tc * ne + e;
                            d[8*(e*esb+b) +: 8] = (j < n) ? src_byte(tr*ne+r, j, b, seed) : 8'hEE;
                        end
                    end
                    send_beat(d, bp);
                end
            end
        end
        i_valid = 1'b0;
    endtask

    task automatic consumer(input int shf, input int m, input int n, input bit bp,
                            input int seed, input int total);
        int ne, esb, tc_n, q;
        bit prev_stall;
        logic [8*BB-1:0] prev_dat;
        logic [BB-1:0] prev_stb;
        ne = BB >> shf; esb = 1 << shf;
        tc_n = (n + ne - 1) / ne;
        q = 0; prev_stall = 1'b0; prev_dat = '0; prev_stb = '0;
        while (q < total) begin
            @(negedge clk);
            if (prev_stall) begin
                check(o_vld && o_dat == prev_dat && o_stb == prev_stb, "R7", "stalled beat changed",
                      {o_dat}, {prev_dat});
            end
            prev_stall = o_vld && !o_ready;
            prev_dat = o_dat; prev_stb = o_stb;
            if (o_vld && o_ready) begin
                int t, c, tr, tc;
                logic [BB-1:0] es;
                logic [8*BB-1:0] ed, mask;
                t = q / ne; c = q % ne; tr = t / tc_n; tc = t % tc_n;
                for (int k = 0; k < BB; k++) begin
                    int i, j;
                    i = tr * ne + (k >> shf);
                    j = tc * ne + c;
                    es[k] = (i < m) && (j < n);
                    ed[8*k +: 8] = es[k] ? src_byte(i, j, k & (esb - 1), seed) : 8'h00;
                    mask[8*k +: 8] = {8{es[k]}};
                end
                check(o_stb == es, "R3/R4", $sformatf("strobe beat %0d", q), {56'd0, o_stb}, {56'd0, es});
                check((o_dat & mask) == ed, "R1/R2", $sformatf("data beat %0d", q), o_dat & mask, ed);
                q++;
            end
            @(posedge clk); #1;
            o_ready = bp ? ($urandom_range(0, 3) != 0) : 1'b1;
        end
        o_ready = 1'b1;
    endtask

    task automatic run_case(input logic [1:0] code, input int m, input int n, input bit half,
                            input bit bp, input int seed, input int exp_beats);
        int shf, ne, total;
        shf = (code == 2'd1) ? 1 : (code == 2'd2) ? 2 : 0;
        ne = BB >> shf;
        total = ((m + ne - 1) / ne) * ((n + ne - 1) / ne) * ne;
        check(total == exp_beats, "R2", "output beat count", 64'(total), 64'(exp_beats));
        sel = half; esz = code; dim_m = 8'(m); dim_n = 8'(n);
        o_ready = 1'b1;
        first_fire = -1; last_fire = -1;
        pulse_clear();
        fork
            producer(shf, m, n, bp, seed);
            consumer(shf, m, n, bp, seed, total);
        join
        @(negedge clk);
        check(!i_rdy, "R9", "in_ready after last tile", {63'd0, i_rdy}, 64'd0);
        check(!o_vld, "R2", "out_valid after last column", {63'd0, o_vld}, 64'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_checks++; n_fail++;
            $display("FAIL R2 watchdog: actual hang expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        check(!out_valid0 && !out_valid1, "R8", "out_valid after reset", {63'd0, out_valid0 | out_valid1}, 64'd0);
        check(in_ready0 && in_ready1, "R8", "in_ready after reset", {63'd0, in_ready0 & in_ready1}, 64'd1);
        @(posedge clk); #1;

        // Table of shapes, element sizes, bank modes
        foreach (VECS[v]) begin
            run_case(VECS[v].esz, int'(VECS[v].m), int'(VECS[v].n), VECS[v].half,
                     VECS[v].bp, v + 3, int'(VECS[v].beats));
        end

        // R5: two banks, two stacked tiles, no stall
        run_case(2'd0, 16, 8, 1'b0, 1'b0, 40, 16);
        check(last_fire - first_fire == 15, "R5", "input acceptance span",
              64'(last_fire - first_fire), 64'd15);

        // R6: one bank, same shape
        run_case(2'd0, 16, 8, 1'b1, 1'b0, 41, 16);
        check(last_fire - first_fire == 23, "R6", "input acceptance span",
              64'(last_fire - first_fire), 64'd23);

        // R10 / R9 / R8: fill one tile with output stalled, then clear
        sel = 1'b0; esz = 2'd0; dim_m = 8'd8; dim_n = 8'd8;
        pulse_clear();
        o_ready = 1'b0;
        for (int r = 0; r < 8; r++) send_beat({8{8'(r)}}, 1'b0);
        i_valid = 1'b0;
        @(negedge clk);
        check(out_valid0, "R10", "first column one cycle after last row", {63'd0, out_valid0}, 64'd1);
        check(!in_ready0, "R9", "in_ready after single-tile transfer", {63'd0, in_ready0}, 64'd0);
        @(posedge clk); #1;
        pulse_clear();
        @(negedge clk);
        check(!out_valid0 && in_ready0, "R8", "idle after clear of full bank",
              {62'd0, out_valid0, in_ready0}, 64'd1);
        @(posedge clk); #1;
        o_ready = 1'b1;

        // R8: clear mid-tile, then a short transfer must show no stale rows
        for (int r = 0; r < 3; r++) send_beat({8{8'hC3}}, 1'b0);
        i_valid = 1'b0;
        pulse_clear();
        @(negedge clk);
        check(!out_valid0 && in_ready0, "R8", "idle after clear of partial tile",
              {62'd0, out_valid0, in_ready0}, 64'd1);
        @(posedge clk); #1;
        run_case(2'd0, 2, 8, 1'b0, 1'b1, 55, 8);
        run_case(2'd1, 2, 3, 1'b1, 1'b1, 56, 4);

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule